// File: doc/BRIEF.md
# Configurable Capture/Compare Timer Channel

This block is a single timer channel that sits beside a shared 16-bit up-counter. The counter itself is outside the block: the block receives the count value and a one-cycle overflow strobe, and it treats both as plain inputs. One channel register and one 2-bit select field serve two jobs. In compare mode the register holds a match time, and the select field picks what happens to the pin when the count reaches it. In input capture mode the register receives a timestamp of the count when a chosen edge arrives on the pin, and the select field picks which edge.

A small state machine follows the configuration inputs with one register of delay. It has three states. ST_PLAIN means the pin is plain I/O and the channel does nothing. ST_CMP is the compare state. ST_CAP is the capture state. The named transitions are arm_compare (to ST_CMP), arm_capture (to ST_CAP), swap_to_capture (ST_CMP to ST_CAP), swap_to_compare (ST_CAP to ST_CMP) and release (to ST_PLAIN). Without a configuration change, every state holds itself.

A sticky flag records each event. Software clears it with a write-one strobe. An interrupt request is the flag masked by an enable. With toggle-on-overflow set, the compare output can also toggle on each counter wrap, which gives an edge-aligned PWM together with a clear or set action on match.

Top module: `tmr_chan_unit`

## Requirements
- R1: After reset, pin_out, pin_oe, reg_rd_data, chan_flag and irq are all zero.
- R2: The state register updates on every clock from the inputs of the previous cycle. A select of 00 gives ST_PLAIN. Mode 1 with a nonzero select gives ST_CMP. Mode 0 with a nonzero select gives ST_CAP. pin_oe is 1 only in ST_CMP.
- R3: In ST_CMP, cnt_val equal to the channel register is a match. A match sets chan_flag on the next edge. The pin action comes from the live select: 01 toggles pin_out, 10 drives it to 0, 11 drives it to 1.
- R4: In ST_CMP with cfg_tog_ovf = 1, every cycle with cnt_ovf = 1 toggles pin_out on the next edge.
- R5: When an overflow toggle and a match fall in the same cycle, the toggle is applied first and the match action second. A clear or a set therefore wins, and toggle on top of toggle leaves pin_out unchanged.
- R6: pin_in passes through two synchroniser flops and one history flop. With a live select of 01 (rising), 10 (falling) or 11 (either edge), a qualifying edge in ST_CAP loads cnt_val into the channel register and sets chan_flag. Take a pin_in change first sampled at clock edge k. The register then holds the cnt_val present at edge k+2.
- R7: In ST_CAP, edges that the select does not qualify change neither the register nor the flag. In ST_PLAIN, no match and no edge sets the flag.
- R8: chan_flag stays set until a cycle with flag_clr = 1. An event in the same cycle as a clear leaves the flag set.
- R9: irq equals chan_flag AND cfg_irq_en, combinationally.
- R10: reg_wr_en = 1 loads reg_wr_data on the next edge in any state. A capture in the same cycle takes priority over the write.
- R11: Outside ST_CMP, pin_out holds its value, and overflow strobes do not toggle it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_out_mode | input | 1 | 1 = compare, 0 = capture |
| cfg_sel | input | 2 | Pin action or capture edge select |
| cfg_tog_ovf | input | 1 | Toggle pin on counter overflow |
| cfg_irq_en | input | 1 | Interrupt enable |
| cnt_val | input | 16 | Shared counter value |
| cnt_ovf | input | 1 | Counter overflow strobe |
| reg_wr_en | input | 1 | Channel register write strobe |
| reg_wr_data | input | 16 | Channel register write data |
| flag_clr | input | 1 | Write-one-to-clear for the flag |
| pin_in | input | 1 | Asynchronous pin input |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| reg_rd_data | output | 16 | Channel register value |
| chan_flag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check these relations on every cycle:
- pin_oe only follows a compare configuration.
- A clear or set match forces the pin level on the next cycle, including when an overflow toggle coincides.
- An overflow alone flips the pin in compare.
- The pin is frozen outside compare.
- A capture stores the count of its cycle.
- A write that no capture overrides lands.
- The flag sets on events and holds until cleared.

Only the bench scenarios can show the end-to-end behaviours, which the bench compares against its reference model:
- The synchroniser latency from pin change to timestamp.
- Which edges qualify under each select code.
- Toggle-on-toggle cancelling at a coinciding wrap.
- Capture winning over a simultaneous write.
- The irq masking.
- Inert behaviour in the plain state.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        ST_PLAIN = 2'd0,
        ST_CMP   = 2'd1,
        ST_CAP   = 2'd2
    } tcu_state_e;

    // select field codes, shared by both functions
    localparam logic [1:0] SEL_OFF = 2'b00; // plain pin
    localparam logic [1:0] SEL_A   = 2'b01; // toggle on match / rising edge
    localparam logic [1:0] SEL_B   = 2'b10; // clear on match / falling edge
    localparam logic [1:0] SEL_C   = 2'b11; // set on match / either edge

endpackage

// File: rtl/tcu_edge_sync.sv
module tcu_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              hist;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= 1'b0;
        else        hist <= chain[LAST];
    end

    assign rise = chain[LAST] & ~hist;
    assign fall = ~chain[LAST] & hist;

endmodule

// File: rtl/tcu_ctrl.sv
module tcu_ctrl
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_out_mode,
    input  logic [1:0] cfg_sel,
    input  logic       cnt_match,
    input  logic       rise,
    input  logic       fall,
    output logic       pin_oe,
    output logic       cmp_en,
    output logic       cmp_hit,
    output logic       cap_load,
    output logic       ch_event
);
    tcu_state_e st, st_nx;
    logic       edge_ok;

    // target state picked by the configuration
    function automatic tcu_state_e pick(input logic md, input logic [1:0] sl);
        if (sl == SEL_OFF) return ST_PLAIN;
        else if (md)       return ST_CMP;
        else               return ST_CAP;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_PLAIN;
        else        st <= st_nx;
    end

    // transitions: arm_compare, arm_capture, swap_to_capture,
    // swap_to_compare, release; otherwise each state holds
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_PLAIN: st_nx = pick(cfg_out_mode, cfg_sel);
            ST_CMP:   st_nx = pick(cfg_out_mode, cfg_sel);
            ST_CAP:   st_nx = pick(cfg_out_mode, cfg_sel);
            default:  st_nx = ST_PLAIN;
        endcase
    end

    always_comb begin
        unique case (cfg_sel)
            SEL_A:   edge_ok = rise;
            SEL_B:   edge_ok = fall;
            SEL_C:   edge_ok = rise | fall;
            default: edge_ok = 1'b0;
        endcase
    end

    always_comb begin
        pin_oe   = 1'b0;
        cmp_en   = 1'b0;
        cmp_hit  = 1'b0;
        cap_load = 1'b0;
        unique case (st)
            ST_PLAIN: ;
            ST_CMP: begin
                pin_oe  = 1'b1;
                cmp_en  = 1'b1;
                cmp_hit = cnt_match;
            end
            ST_CAP: cap_load = edge_ok;
            default: ;
        endcase
        ch_event = cmp_hit | cap_load;
    end

    assert_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> ($past(cfg_out_mode) && ($past(cfg_sel) != SEL_OFF)));

    assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_hit && cap_load));

endmodule

// File: rtl/tcu_chan_reg.sv
module tcu_chan_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cap_load,
    input  logic             ch_event,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] value,
    output logic             match,
    output logic             flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        value <= '0;
        else if (cap_load) value <= cnt_val;
        else if (wr_en)    value <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (ch_event) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    assign match = (cnt_val == value);

    assert_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_load |=> (value == $past(cnt_val)));

    assert_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cap_load) |=> (value == $past(wr_data)));

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ch_event |=> flag);

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

endmodule

// File: rtl/tcu_pin_drv.sv
module tcu_pin_drv
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmp_en,
    input  logic       cmp_hit,
    input  logic       tog_ovf,
    input  logic       cnt_ovf,
    input  logic [1:0] cfg_sel,
    output logic       pin_out
);
    logic pin_nx;
    logic wrap_flip;

    assign wrap_flip = cmp_en & tog_ovf & cnt_ovf;

    // overflow toggle first, match action second
    always_comb begin
        pin_nx = pin_out;
        if (wrap_flip) pin_nx = ~pin_nx;
        if (cmp_hit) begin
            unique case (cfg_sel)
                SEL_A:   pin_nx = ~pin_nx;
                SEL_B:   pin_nx = 1'b0;
                SEL_C:   pin_nx = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_out <= 1'b0;
        else        pin_out <= pin_nx;
    end

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && cfg_sel == SEL_B) |=> !pin_out);

    assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_hit && cfg_sel == SEL_C) |=> pin_out);

    assert_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_flip && !cmp_hit) |=> (pin_out != $past(pin_out)));

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable(pin_out));

endmodule

// File: rtl/tmr_chan_unit.sv
module tmr_chan_unit
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_out_mode,
    input  logic [1:0]       cfg_sel,
    input  logic             cfg_tog_ovf,
    input  logic             cfg_irq_en,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_ovf,
    input  logic             reg_wr_en,
    input  logic [CNT_W-1:0] reg_wr_data,
    input  logic             flag_clr,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic [CNT_W-1:0] reg_rd_data,
    output logic             chan_flag,
    output logic             irq
);
    logic rise, fall, match, cmp_en, cmp_hit, cap_load, ch_event;

    tcu_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .rise   (rise),
        .fall   (fall)
    );

    tcu_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_out_mode (cfg_out_mode),
        .cfg_sel      (cfg_sel),
        .cnt_match    (match),
        .rise         (rise),
        .fall         (fall),
        .pin_oe       (pin_oe),
        .cmp_en       (cmp_en),
        .cmp_hit      (cmp_hit),
        .cap_load     (cap_load),
        .ch_event     (ch_event)
    );

    tcu_chan_reg #(.CNT_W(CNT_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_val  (cnt_val),
        .wr_en    (reg_wr_en),
        .wr_data  (reg_wr_data),
        .cap_load (cap_load),
        .ch_event (ch_event),
        .flag_clr (flag_clr),
        .value    (reg_rd_data),
        .match    (match),
        .flag     (chan_flag)
    );

    tcu_pin_drv u_pin (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_en  (cmp_en),
        .cmp_hit (cmp_hit),
        .tog_ovf (cfg_tog_ovf),
        .cnt_ovf (cnt_ovf),
        .cfg_sel (cfg_sel),
        .pin_out (pin_out)
    );

    assign irq = chan_flag & cfg_irq_en;

endmodule

// File: tb/sim_tmr_chan_unit.sv
module sim_tmr_chan_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_out_mode = 1'b0;
    logic [1:0]  cfg_sel = 2'b00;
    logic        cfg_tog_ovf = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic [15:0] cnt_val = 16'd0;
    logic        cnt_ovf = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wr_data = 16'd0;
    logic        flag_clr = 1'b0;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, chan_flag, irq;
    logic [15:0] reg_rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int cnt_mod = 15;
    bit cnt_run = 1'b0;

    // reference model state
    int          m_st = 0;        // 0 plain, 1 compare, 2 capture
    logic        m_pin = 1'b0;
    logic [15:0] m_reg = 16'd0;
    logic        m_flag = 1'b0;
    logic        m_seen[$];       // pin samples at the last three edges, oldest first

    always #2 clk = ~clk;         // 250 MHz

    tmr_chan_unit u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_out_mode (cfg_out_mode),
        .cfg_sel      (cfg_sel),
        .cfg_tog_ovf  (cfg_tog_ovf),
        .cfg_irq_en   (cfg_irq_en),
        .cnt_val      (cnt_val),
        .cnt_ovf      (cnt_ovf),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_data  (reg_wr_data),
        .flag_clr     (flag_clr),
        .pin_in       (pin_in),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .reg_rd_data  (reg_rd_data),
        .chan_flag    (chan_flag),
        .irq          (irq)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
        end
    endtask

    // advance the model by one clock edge using the inputs now applied
    task automatic model_step();
        logic now_v, old_v, qual, hit, capt, p;
        logic [15:0] r;
        now_v = m_seen[1];
        old_v = m_seen[0];
        void'(m_seen.pop_front());
        m_seen.push_back(pin_in);
        case (cfg_sel)
            2'b01:   qual = now_v && !old_v;
            2'b10:   qual = !now_v && old_v;
            2'b11:   qual = (now_v != old_v);
            default: qual = 1'b0;
        endcase
        hit  = (m_st == 1) && (cnt_val == m_reg);
        capt = (m_st == 2) && qual;
        p = m_pin;
        if (m_st == 1 && cfg_tog_ovf && cnt_ovf) p = !p;
        if (hit) begin
            if (cfg_sel == 2'b01) p = !p;
            else if (cfg_sel == 2'b10) p = 1'b0;
            else if (cfg_sel == 2'b11) p = 1'b1;
        end
        r = capt ? cnt_val : (reg_wr_en ? reg_wr_data : m_reg);
        if (hit || capt) m_flag = 1'b1;
        else if (flag_clr) m_flag = 1'b0;
        m_pin = p;
        m_reg = r;
        m_st  = (cfg_sel == 2'b00) ? 0 : (cfg_out_mode ? 1 : 2);
    endtask

    task automatic compare_all();
        chk(pin_out == m_pin, "R3 R4 R5 R11 pin_out", pin_out, m_pin);
        chk(pin_oe == (m_st == 1), "R2 pin_oe", pin_oe, (m_st == 1));
        chk(reg_rd_data == m_reg, "R6 R10 reg_rd_data", reg_rd_data, m_reg);
        chk(chan_flag == m_flag, "R7 R8 chan_flag", chan_flag, m_flag);
        chk(irq == (m_flag & cfg_irq_en), "R9 irq", irq, m_flag & cfg_irq_en);
    endtask

    task automatic cyc();
        model_step();
        @(negedge clk);
        compare_all();
        if (cnt_run) begin
            if (int'(cnt_val) >= cnt_mod) cnt_val = 16'd0;
            else cnt_val = cnt_val + 16'd1;
            cnt_ovf = (int'(cnt_val) == cnt_mod);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        reg_wr_en = 1'b1;
        reg_wr_data = d;
        cyc();
        reg_wr_en = 1'b0;
    endtask

    task automatic clr();
        flag_clr = 1'b1;
        cyc();
        flag_clr = 1'b0;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            pin_in = 1'b1;
            repeat (3 + i) cyc();
            pin_in = 1'b0;
            repeat (4) cyc();
            if (i % 2 == 1) clr();
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        m_seen = '{1'b0, 1'b0, 1'b0};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(pin_out == 1'b0, "R1 pin_out", pin_out, 0);
        chk(pin_oe == 1'b0, "R1 pin_oe", pin_oe, 0);
        chk(reg_rd_data == 16'd0, "R1 reg_rd_data", reg_rd_data, 0);
        chk(chan_flag == 1'b0, "R1 chan_flag", chan_flag, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        rst_n = 1'b1;
        cyc();

        // R3 toggle on match with interrupt enabled (R9)
        cfg_out_mode = 1'b1; cfg_sel = 2'b01; cfg_irq_en = 1'b1;
        cnt_mod = 15; cnt_run = 1'b1;
        wr(16'd5);
        repeat (40) cyc();
        clr();
        cfg_irq_en = 1'b0;
        repeat (20) cyc();
        cfg_irq_en = 1'b1;

        // R4 PWM: clear on match plus toggle on overflow, then set on match
        cfg_sel = 2'b10; cfg_tog_ovf = 1'b1; cnt_mod = 9;
        wr(16'd4);
        repeat (40) cyc();
        cfg_sel = 2'b11;
        repeat (30) cyc();

        // R5 match coinciding with the overflow strobe
        wr(16'd9);
        cfg_sel = 2'b10;
        repeat (25) cyc();
        cfg_sel = 2'b01;
        repeat (25) cyc();
        cfg_sel = 2'b11;
        repeat (15) cyc();

        // R8 clear held across events: event wins
        flag_clr = 1'b1;
        repeat (30) cyc();
        flag_clr = 1'b0;
        cfg_tog_ovf = 1'b0;
        repeat (10) cyc();

        // R7 R11 plain state: pin moves, matches occur, nothing reacts
        clr();
        cfg_sel = 2'b00; cfg_tog_ovf = 1'b1;
        pulses(2);
        repeat (20) cyc();

        // R6 capture on rising, falling and either edge; R7 non-qualifying edges
        cfg_out_mode = 1'b0; cnt_mod = 200;
        cfg_sel = 2'b01;
        clr();
        pulses(4);
        cfg_sel = 2'b10;
        pulses(4);
        cfg_sel = 2'b11;
        pulses(4);

        // R10 writes in capture state, including one colliding with a capture
        reg_wr_en = 1'b1; reg_wr_data = 16'hABCD;
        pin_in = 1'b1;
        repeat (8) cyc();
        pin_in = 1'b0;
        repeat (8) cyc();
        reg_wr_en = 1'b0;
        wr(16'h1234);
        repeat (5) cyc();

        // R2 release back to plain
        cfg_sel = 2'b00;
        repeat (5) cyc();

        summary();
        $finish;
    end

endmodule